// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block sends parallel audio samples as a time-division multiplexed serial stream. It produces its own bit clock, frame sync and serial data pin. A frame holds a programmable number of slots. Every slot is a programmable number of bit periods wide, and that width may exceed the sample width. One mask bit per slot decides whether the slot carries a sample or stays silent.

A three-bit format field selects how the frame sync is shaped and where the sample sits in its slot. Bit 0 moves the sync one bit period earlier. Bit 1 makes the sync one bit long instead of one slot long. Bit 2 places the sample at the end of the slot instead of the start. The five supported codes are:

| Code | Format |
| --- | --- |
| 000 | left-justified |
| 001 | I2S |
| 010 | DSP-B |
| 011 | DSP-A |
| 100 | right-justified |

Two separate bits invert the bit clock and the frame sync. Samples arrive through a ready/valid word port. The block raises a one-cycle flag after the last slot of each frame. It also keeps a sticky flag for samples that were not available in time.

Top module: `tdm_tx`

## Requirements
- R1: Each bit period lasts two `clk` cycles. In the first cycle `sclkOut` equals `cfgClkInv`, and in the second cycle it is the inverse. `sdOut` and `fsOut` change only at the start of a bit period.
- R2: When `cfgFmt[2]`=0, bit b of an enabled slot carries sample bit WORD_W-1-b for b < WORD_W. The remaining bits of the slot are zero.
- R3: When `cfgFmt[2]`=1, the first slotBits-WORD_W bits of an enabled slot are zero. The sample then follows, MSB first, and fills the end of the slot.
- R4: When `cfgFmt[1]`=0, the sync is active for the whole span of slot 0. `cfgFmt[0]`=1 moves that span one bit period earlier. Code 001 drives the active level low. All other codes drive it high.
- R5: When `cfgFmt[1]`=1, the sync is active for a single bit period. With code 010 that bit is bit 0 of slot 0. With code 011 it is the last bit of the preceding frame.
- R6: `cfgFsInv`=1 inverts the level of `fsOut` in every format, including while idle.
- R7: A frame holds `cfgSlots` slots of `cfgSlotBits` bits each. A `cfgSlots` value of 0 selects 2 slots.
- R8: Bit i of `slotMask` enables slot i. A disabled slot sends zeros and requests no sample.
- R9: `wordReady` is high for exactly one `clk` cycle, in the cycle just before the first bit of each enabled slot. `wordData` is taken at the end of that cycle if `wordValid` is high.
- R10: If `wordValid` is low when a sample is requested, the slot sends zeros and `underrun` sets. `underrun` stays set until a clock edge sees `urClear`=1. If an underrun occurs on the same edge, setting wins over clearing.
- R11: `lastSlot` is a one-cycle pulse in the first `clk` cycle of the bit period that follows the last bit of a frame.
- R12: While `enable` is low:
  - `sdOut` is 0.
  - `sclkOut` equals `cfgClkInv`.
  - `fsOut` is at its inactive level.
  - No sample is requested.

  After `enable` rises, one lead-in bit period comes before frame 0. During the lead-in `sdOut` is 0, and in early-sync formats the sync is already active.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Block clock, twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the frame engine when high |
| cfgFmt | input | 3 | Format: [0] early sync, [1] one-bit sync, [2] right-justified |
| cfgSlots | input | $clog2(SLOTS_MAX+1) | Slots per frame, 0 selects 2 |
| cfgSlotBits | input | $clog2(SLOT_W_MAX+1) | Bits per slot, WORD_W to SLOT_W_MAX |
| cfgClkInv | input | 1 | Inverts the bit clock |
| cfgFsInv | input | 1 | Inverts the frame sync |
| slotMask | input | SLOTS_MAX | Per-slot enable, bit i is slot i |
| wordData | input | WORD_W | Sample to send |
| wordValid | input | 1 | `wordData` holds a sample |
| wordReady | output | 1 | Sample taken this cycle if valid |
| urClear | input | 1 | Clears the underrun flag |
| sclkOut | output | 1 | Bit clock |
| fsOut | output | 1 | Frame sync |
| sdOut | output | 1 | Serial data |
| lastSlot | output | 1 | Pulse after the last bit of a frame |
| underrun | output | 1 | Sticky missing-sample flag |

## Verification
The properties assume that `cfgClkInv` and the rest of the configuration stay constant while `enable` is high. They also assume that `cfgSlotBits` stays between WORD_W and SLOT_W_MAX. The stimulus changes configuration only while `enable` is low, and only after the engine has been idle for a full bit period. The sweep keeps slot widths inside that range. The sample source presents each new word only after the previous request cycle has closed. Inputs move a fixed delay after the falling clock edge, so no request overlaps a data change.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  // Bit positions inside the format field
  localparam int FMT_EARLY_BIT = 0;
  localparam int FMT_SHORT_BIT = 1;
  localparam int FMT_RIGHT_BIT = 2;

  typedef enum logic [2:0] {
    FMT_LJ   = 3'b000,
    FMT_I2S  = 3'b001,
    FMT_DSPB = 3'b010,
    FMT_DSPA = 3'b011,
    FMT_RJ   = 3'b100
  } fmt_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSlot;  // a new slot starts at this edge
    logic slotOn;    // that slot is enabled by the mask
  } tx_strobe_t;
endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
#(
  parameter int SLOT_W_MAX = 32,
  parameter int SLOTS_MAX  = 8,
  parameter int DEF_SLOTS  = 2,
  localparam int SI_W = (SLOTS_MAX > 1) ? $clog2(SLOTS_MAX) : 1,
  localparam int BI_W = $clog2(SLOT_W_MAX),
  localparam int SC_W = $clog2(SLOTS_MAX + 1),
  localparam int BC_W = $clog2(SLOT_W_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic [2:0]           cfgFmt,
  input  logic [SC_W-1:0]      cfgSlots,
  input  logic [BC_W-1:0]      cfgSlotBits,
  input  logic                 cfgClkInv,
  input  logic                 cfgFsInv,
  input  logic [SLOTS_MAX-1:0] slotMask,
  output tx_strobe_t           strb,
  output logic [BI_W-1:0]      bitIdx,
  output logic                 sclkOut,
  output logic                 fsOut,
  output logic                 wordReady,
  output logic                 lastSlot
);
  logic [SC_W-1:0] effSlots;
  logic [SI_W-1:0] lastSlotIdx, slotIdx, nxtSlot, refSlot;
  logic [BI_W-1:0] lastBitIdx, nxtBit, refBit;
  logic half, warm, endOfSlot, endOfFrame, advance, fsAct, baseLow;

  assign effSlots    = (cfgSlots == '0) ? SC_W'(DEF_SLOTS) : cfgSlots;
  assign lastSlotIdx = SI_W'(effSlots - SC_W'(1));
  assign lastBitIdx  = BI_W'(cfgSlotBits - BC_W'(1));

  assign endOfSlot  = (bitIdx == lastBitIdx);
  assign endOfFrame = endOfSlot && (slotIdx == lastSlotIdx);

  always_comb begin
    nxtBit  = endOfSlot ? '0 : bitIdx + BI_W'(1);
    nxtSlot = slotIdx;
    if (endOfSlot) nxtSlot = endOfFrame ? '0 : slotIdx + SI_W'(1);
  end

  // A bit ends on the second half of its period
  assign advance       = enable && half;
  assign strb.loadSlot = advance && (nxtBit == '0);
  assign strb.slotOn   = slotMask[nxtSlot];
  assign wordReady     = strb.loadSlot && strb.slotOn;

  // Frame sync: early styles look one bit ahead
  assign refSlot = cfgFmt[FMT_EARLY_BIT] ? nxtSlot : slotIdx;
  assign refBit  = cfgFmt[FMT_EARLY_BIT] ? nxtBit  : bitIdx;
  assign fsAct   = enable && (refSlot == '0) &&
                   (!cfgFmt[FMT_SHORT_BIT] || (refBit == '0));
  assign baseLow = cfgFmt[FMT_EARLY_BIT] && !cfgFmt[FMT_SHORT_BIT];
  assign fsOut   = fsAct ^ baseLow ^ cfgFsInv;
  assign sclkOut = half ^ cfgClkInv;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      // Park on the last bit so the lead-in bit precedes frame 0
      half     <= 1'b0;
      warm     <= 1'b0;
      bitIdx   <= lastBitIdx;
      slotIdx  <= lastSlotIdx;
      lastSlot <= 1'b0;
    end else begin
      half     <= !half;
      lastSlot <= advance && warm && endOfFrame;
      if (advance) begin
        bitIdx  <= nxtBit;
        slotIdx <= nxtSlot;
        warm    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_tx_dpath.sv
module tdm_tx_dpath
  import tdm_tx_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int SLOT_W_MAX = 32,
  localparam int BI_W = $clog2(SLOT_W_MAX),
  localparam int BC_W = $clog2(SLOT_W_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  tx_strobe_t        strb,
  input  logic [BI_W-1:0]   bitIdx,
  input  logic [BC_W-1:0]   cfgSlotBits,
  input  logic              rightJust,
  input  logic [WORD_W-1:0] wordData,
  input  logic              wordValid,
  input  logic              urClear,
  output logic              sdOut,
  output logic              underrun
);
  logic [WORD_W-1:0] holdWord, aligned;
  logic [BC_W-1:0]   bitPos, pad, pos;
  logic              live, inWord;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      holdWord <= '0;
      live     <= 1'b0;
    end else if (strb.loadSlot) begin
      live     <= strb.slotOn;
      holdWord <= (strb.slotOn && wordValid) ? wordData : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) underrun <= 1'b0;
    else if (enable && strb.loadSlot && strb.slotOn && !wordValid) underrun <= 1'b1;
    else if (urClear) underrun <= 1'b0;
  end

  // Place the sample at the slot start or its end, MSB first
  always_comb begin
    bitPos = BC_W'(bitIdx);
    pad    = cfgSlotBits - BC_W'(WORD_W);
    if (rightJust) begin
      inWord = (bitPos >= pad);
      pos    = bitPos - pad;
    end else begin
      inWord = (bitPos < BC_W'(WORD_W));
      pos    = bitPos;
    end
    aligned = holdWord << pos;
  end

  assign sdOut = enable && live && inWord && aligned[WORD_W-1];
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int SLOT_W_MAX = 32,
  parameter int SLOTS_MAX  = 8,
  parameter int DEF_SLOTS  = 2,
  localparam int SC_W = $clog2(SLOTS_MAX + 1),
  localparam int BC_W = $clog2(SLOT_W_MAX + 1),
  localparam int BI_W = $clog2(SLOT_W_MAX)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic [2:0]           cfgFmt,
  input  logic [SC_W-1:0]      cfgSlots,
  input  logic [BC_W-1:0]      cfgSlotBits,
  input  logic                 cfgClkInv,
  input  logic                 cfgFsInv,
  input  logic [SLOTS_MAX-1:0] slotMask,
  input  logic [WORD_W-1:0]    wordData,
  input  logic                 wordValid,
  output logic                 wordReady,
  input  logic                 urClear,
  output logic                 sclkOut,
  output logic                 fsOut,
  output logic                 sdOut,
  output logic                 lastSlot,
  output logic                 underrun
);
  tx_strobe_t      strb;
  logic [BI_W-1:0] bitIdx;

  tdm_tx_ctrl #(
    .SLOT_W_MAX(SLOT_W_MAX), .SLOTS_MAX(SLOTS_MAX), .DEF_SLOTS(DEF_SLOTS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .cfgFmt(cfgFmt),
    .cfgSlots(cfgSlots), .cfgSlotBits(cfgSlotBits),
    .cfgClkInv(cfgClkInv), .cfgFsInv(cfgFsInv), .slotMask(slotMask),
    .strb(strb), .bitIdx(bitIdx), .sclkOut(sclkOut), .fsOut(fsOut),
    .wordReady(wordReady), .lastSlot(lastSlot)
  );

  tdm_tx_dpath #(
    .WORD_W(WORD_W), .SLOT_W_MAX(SLOT_W_MAX)
  ) u_dpath (
    .clk(clk), .rst(rst), .enable(enable), .strb(strb), .bitIdx(bitIdx),
    .cfgSlotBits(cfgSlotBits), .rightJust(cfgFmt[FMT_RIGHT_BIT]),
    .wordData(wordData), .wordValid(wordValid), .urClear(urClear),
    .sdOut(sdOut), .underrun(underrun)
  );
endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic cfgClkInv,
  input logic sclkOut,
  input logic sdOut,
  input logic wordReady,
  input logic wordValid,
  input logic urClear,
  input logic underrun,
  input logic lastSlot
);
  assert_sclk_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && enable && $past(enable) && $stable(cfgClkInv)
      |-> sclkOut != $past(sclkOut));

  assert_ready_single_R9: assert property (@(posedge clk) disable iff (rst)
    wordReady |=> !wordReady);

  assert_underrun_set_R10: assert property (@(posedge clk) disable iff (rst)
    wordReady && !wordValid |=> underrun);

  assert_underrun_hold_R10: assert property (@(posedge clk) disable iff (rst)
    underrun && !urClear |=> underrun);

  assert_last_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    lastSlot |=> !lastSlot);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !wordReady && !sdOut);
endmodule

bind tdm_tx tdm_tx_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .cfgClkInv(cfgClkInv),
  .sclkOut(sclkOut), .sdOut(sdOut), .wordReady(wordReady),
  .wordValid(wordValid), .urClear(urClear), .underrun(underrun),
  .lastSlot(lastSlot)
);

// File: tb/test_tdm_tx.sv
module test_tdm_tx;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 4;
  localparam int SLOT_W_MAX = 8;
  localparam int SLOTS_MAX  = 4;
  localparam int DEF_SLOTS  = 2;
  localparam int SC_W = $clog2(SLOTS_MAX + 1);
  localparam int BC_W = $clog2(SLOT_W_MAX + 1);

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0;
  logic [2:0] cfgFmt = 3'b000;
  logic [SC_W-1:0] cfgSlots = '0;
  logic [BC_W-1:0] cfgSlotBits = BC_W'(WORD_W);
  logic cfgClkInv = 1'b0, cfgFsInv = 1'b0, urClear = 1'b0, supplyOn = 1'b0;
  logic [SLOTS_MAX-1:0] slotMask = '0;
  logic [WORD_W-1:0] wordData;
  logic wordValid, wordReady, sclkOut, fsOut, sdOut, lastSlot, underrun;

  int nChecks = 0, nErrors = 0, wordCnt = 0, readyCount = 0;
  bit bump = 1'b0;

  function automatic logic [WORD_W-1:0] wordOf(input int k);
    return WORD_W'(k * 11 + 9);
  endfunction

  assign wordData  = wordOf(wordCnt);
  assign wordValid = supplyOn;

  tdm_tx #(.WORD_W(WORD_W), .SLOT_W_MAX(SLOT_W_MAX), .SLOTS_MAX(SLOTS_MAX),
           .DEF_SLOTS(DEF_SLOTS)) i_tdm_tx (
    .clk(clk), .rst(rst), .enable(enable), .cfgFmt(cfgFmt),
    .cfgSlots(cfgSlots), .cfgSlotBits(cfgSlotBits), .cfgClkInv(cfgClkInv),
    .cfgFsInv(cfgFsInv), .slotMask(slotMask), .wordData(wordData),
    .wordValid(wordValid), .wordReady(wordReady), .urClear(urClear),
    .sclkOut(sclkOut), .fsOut(fsOut), .sdOut(sdOut), .lastSlot(lastSlot),
    .underrun(underrun)
  );

  always #(CLK_PERIOD / 2) clk = !clk;

  // Sample source: the next word appears one cycle after a request
  always @(negedge clk) begin
    if (bump) wordCnt++;
    bump = wordReady;
    if (wordReady) readyCount++;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic fsExpect(input int n, input int fb, input int bits,
                                    input logic [2:0] fmt, input bit fi);
    int q, pq;
    bit act;
    q   = fmt[0] ? n + 1 : n;
    pq  = ((q % fb) + fb) % fb;
    act = fmt[1] ? (pq == 0) : (pq < bits);
    return act ^ (fmt[0] && !fmt[1]) ^ fi;
  endfunction

  task automatic runCase(input logic [2:0] fmt, input int slots, input int bits,
                         input logic [SLOTS_MAX-1:0] mask, input bit ci,
                         input bit fi, input bit sup, input int frames);
    int effS, fb, popF, f, p, s, b, k, pad;
    logic [WORD_W-1:0] w;
    logic expSd;
    string fsTag, sdTag;
    @(negedge clk); #2;
    cfgFmt = fmt; cfgSlots = SC_W'(slots); cfgSlotBits = BC_W'(bits);
    slotMask = mask; cfgClkInv = ci; cfgFsInv = fi; supplyOn = sup;
    wordCnt = 0; readyCount = 0;
    effS = (slots == 0) ? DEF_SLOTS : slots;
    fb = effS * bits;
    popF = 0;
    for (int i = 0; i < effS; i++) popF += int'(mask[i]);
    fsTag = fi ? "R6" : (fmt[1] ? "R5" : "R4");
    // idle levels
    @(negedge clk);
    check("R12", "idle sclk", 32'(sclkOut), 32'(ci));
    check("R12", "idle fs", 32'(fsOut), 32'((fmt[0] && !fmt[1]) ^ fi));
    check("R12", "idle sd", 32'(sdOut), 0);
    #2 enable = 1'b1;
    // lead-in bit, second half
    @(negedge clk);
    check("R12", "lead-in sd", 32'(sdOut), 0);
    check("R1", "lead-in sclk", 32'(sclkOut), 32'(!ci));
    check(fsTag, "lead-in fs", 32'(fsOut), 32'(fsExpect(-1, fb, bits, fmt, fi)));
    for (int n = 0; n < frames * fb; n++) begin
      @(negedge clk);
      check("R1", "first-half sclk", 32'(sclkOut), 32'(ci));
      check((slots == 0) ? "R7" : "R11", "lastSlot", 32'(lastSlot),
            32'(n > 0 && (n % fb) == 0));
      @(negedge clk);
      check("R1", "second-half sclk", 32'(sclkOut), 32'(!ci));
      check(fsTag, "fs", 32'(fsOut), 32'(fsExpect(n, fb, bits, fmt, fi)));
      f = n / fb; p = n % fb; s = p / bits; b = p % bits;
      k = f * popF;
      for (int i = 0; i < s; i++) k += int'(mask[i]);
      w = sup ? wordOf(k) : '0;
      pad = bits - WORD_W;
      if (!mask[s]) expSd = 1'b0;
      else if (fmt[2]) expSd = (b < pad) ? 1'b0 : w[WORD_W-1-(b-pad)];
      else expSd = (b < WORD_W) ? w[WORD_W-1-b] : 1'b0;
      sdTag = !mask[s] ? "R8" : (!sup ? "R10" : (fmt[2] ? "R3" : "R2"));
      check(sdTag, "sd", 32'(sdOut), 32'(expSd));
    end
    #2 enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9", "request count", 32'(readyCount), 32'(frames * popF + int'(mask[0])));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErrors++;
    $display("FAIL R1 watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [2:0] fmts [5];
    int slotSet [4];
    int bitSet [2];
    logic [SLOTS_MAX-1:0] masks [4];
    fmts = '{3'b001, 3'b000, 3'b100, 3'b011, 3'b010};
    slotSet = '{0, 1, 3, 4};
    bitSet = '{4, 7};
    masks = '{4'b1111, 4'b1011, 4'b0110, 4'b1101};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12", "reset sd", 32'(sdOut), 0);
    check("R9", "reset ready", 32'(wordReady), 0);
    check("R11", "reset lastSlot", 32'(lastSlot), 0);
    check("R10", "reset underrun", 32'(underrun), 0);

    for (int fi = 0; fi < 5; fi++)
      for (int si = 0; si < 4; si++)
        for (int bi = 0; bi < 2; bi++) begin
          int idx;
          idx = fi * 8 + si * 2 + bi;
          runCase(fmts[fi], slotSet[si], bitSet[bi], masks[(idx / 2) % 4],
                  idx[0], idx[1] ^ idx[3], 1'b1, 2);
        end
    check("R10", "no underrun with supply", 32'(underrun), 0);

    // mask fully off: nothing requested, no underrun even without supply
    runCase(3'b000, 3, 5, 4'b0000, 1'b0, 1'b0, 1'b0, 1);
    check("R8", "silent frame no underrun", 32'(underrun), 0);

    // missing samples
    runCase(3'b100, 2, 6, 4'b0010, 1'b1, 1'b0, 1'b0, 1);
    repeat (4) @(negedge clk);
    check("R10", "underrun sticky", 32'(underrun), 1);
    #2 urClear = 1'b1;
    @(negedge clk);
    #2 urClear = 1'b0;
    @(negedge clk);
    check("R10", "underrun cleared", 32'(underrun), 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule